// File: doc/BRIEF.md
# Column Priority-Token Hit Readout

This block is the digital logic of one column in a hit-driven pixel matrix. Every pixel watches its own discriminator output. On the rising edge it captures the free-running time-stamp bus, and on the falling edge it captures the bus again. The first capture gives the arrival time. The gap between the two captures measures the deposited energy. A captured hit raises the pixel's hit flag. All flags are ORed onto a column fast-OR line, which tells the periphery that the column holds data.

The first accepted hit freezes the whole column. From then on, further discriminator edges are ignored until the column is drained. Pixels whose leading edge falls on that same first cycle are also captured.

Readout waits for an acknowledge from the end-of-column logic. After that, a fixed-priority token picks the lowest-indexed pixel whose trailing stamp is already latched. It presents that pixel's record on a valid/ready stream and clears its flag when the record is accepted. The column reopens only once every flag has been cleared.

Top module: `pcr_column`

## Requirements
- R1: A pixel that accepts a hit stores the time-stamp input sampled on the clock edge where its discriminator is first seen high; this value appears in record bits [23:16].
- R2: The pixel stores the time-stamp input sampled on the edge where its discriminator is first seen low again; this value appears in record bits [15:8].
- R3: The record bits [7:0] carry the pixel index within the column, zero-extended.
- R4: `fastor_o` is high from the clock edge after the first accepted hit, and stays high while any pixel flag is set.
- R5: While any flag is set, leading edges on all pixels are ignored and produce no record. Pixels whose leading edge is seen on the same edge as the first hit are all accepted.
- R6: No record is presented before an `eoc_ack_i` sampled while `fastor_o` is high. An acknowledge sampled while the column is empty has no effect.
- R7: Among pixels that are ready for readout, the lowest index is presented first.
- R8: A pixel whose trailing stamp is not yet latched is skipped. It is presented once its trailing stamp is latched.
- R9: A pixel's flag clears on the edge where its record is accepted (`rec_valid_o` and `rec_ready_i` both high). Each accepted hit yields exactly one record.
- R10: While `rec_valid_o` is high and `rec_ready_i` is low, the next cycle keeps `rec_valid_o` high with unchanged `rec_data_o`.
- R11: Once all flags are cleared, `fastor_o` and `rec_valid_o` go low, and the column accepts new hits from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disc_i | input | NPIX | Per-pixel discriminator outputs, bit i for pixel i |
| tstamp_i | input | TSW | Global time-stamp counter |
| eoc_ack_i | input | 1 | Readout acknowledge from end-of-column logic |
| rec_ready_i | input | 1 | Downstream ready for the record stream |
| fastor_o | output | 1 | OR of all pixel hit flags; high means the column is frozen |
| rec_valid_o | output | 1 | Record on `rec_data_o` is valid |
| rec_data_o | output | 2*TSW+AW | {leading stamp, trailing stamp, pixel address} |

## Verification
Stamps are captured on the edge that first samples a discriminator change. The bench therefore changes a discriminator and the time-stamp bus together at a falling edge, and it expects the stamp to be the value it drove in that same cycle.

`fastor_o` is due one edge after the first leading edge, and an acknowledge takes effect only if it is sampled after that edge. The bench therefore checks the fast-OR in the cycles just before and just after the first hit, and it computes whether each acknowledge was too early.

A record is taken as transferred when valid is seen at a falling edge and ready is driven high for the next rising edge. Under stall, the bench compares each cycle's record against the previous one.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic [1:0] {
    PX_IDLE = 2'd0,
    PX_LEAD = 2'd1,
    PX_DONE = 2'd2
  } px_state_e;
endpackage

// File: rtl/pcr_pixel.sv
module pcr_pixel
  import pcr_pkg::*;
#(
  parameter int TSW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           disc_i,
  input  logic [TSW-1:0] tstamp_i,
  input  logic           frozen_i,
  input  logic           clr_i,
  output logic           flag_o,
  output logic           done_o,
  output logic [TSW-1:0] lead_o,
  output logic [TSW-1:0] trail_o
);
  px_state_e      state_q, state_d;
  logic           disc_q;
  logic [TSW-1:0] lead_q, trail_q;
  logic           rise, fall, lead_en, trail_en;

  assign rise = disc_i & ~disc_q;
  assign fall = ~disc_i & disc_q;

  always_comb begin
    state_d  = state_q;
    lead_en  = 1'b0;
    trail_en = 1'b0;
    unique case (state_q)
      PX_IDLE: if (rise && !frozen_i) begin
        state_d = PX_LEAD;
        lead_en = 1'b1;
      end
      PX_LEAD: if (fall) begin
        state_d  = PX_DONE;
        trail_en = 1'b1;
      end
      PX_DONE: if (clr_i) state_d = PX_IDLE;
      default: state_d = PX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PX_IDLE;
      disc_q  <= 1'b0;
      lead_q  <= '0;
      trail_q <= '0;
    end else begin
      state_q <= state_d;
      disc_q  <= disc_i;
      if (lead_en)  lead_q  <= tstamp_i;
      if (trail_en) trail_q <= tstamp_i;
    end
  end

  assign flag_o  = (state_q != PX_IDLE);
  assign done_o  = (state_q == PX_DONE);
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  // R5
  hit_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> !$past(frozen_i));
  // R9
  flag_clear_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(clr_i));
  // R1
  lead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && $past(flag_o)) |-> $stable(lead_q));
endmodule

// File: rtl/pcr_token.sv
module pcr_token #(
  parameter int NPIX = 60,
  parameter int IW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIX-1:0] elig_i,
  input  logic            ro_en_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [IW-1:0]   sel_o,
  output logic [NPIX-1:0] grant_o
);
  logic [IW-1:0] pick, hold_idx_q, hold_idx_d;
  logic          any, hold_v_q, hold_v_d;

  // lowest index wins
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NPIX - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        pick = IW'(i);
        any  = 1'b1;
      end
    end
  end

  assign sel_o   = hold_v_q ? hold_idx_q : pick;
  assign valid_o = ro_en_i & (hold_v_q | any);
  assign grant_o = (valid_o && ready_i) ? (NPIX'(1) << sel_o) : '0;

  always_comb begin
    hold_v_d   = valid_o & ~ready_i;
    hold_idx_d = sel_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q   <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_v_q   <= hold_v_d;
      hold_idx_q <= hold_idx_d;
    end
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(sel_o)));
endmodule

// File: rtl/pcr_column.sv
module pcr_column #(
  parameter int NPIX = 60,
  parameter int TSW  = 8,
  parameter int AW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPIX-1:0]     disc_i,
  input  logic [TSW-1:0]      tstamp_i,
  input  logic                eoc_ack_i,
  input  logic                rec_ready_i,
  output logic                fastor_o,
  output logic                rec_valid_o,
  output logic [2*TSW+AW-1:0] rec_data_o
);
  localparam int IW = (NPIX > 1) ? $clog2(NPIX) : 1;

  logic            rst_ff1, rst_s;
  logic [NPIX-1:0] flags, dones, grant;
  logic [TSW-1:0]  lead_a  [NPIX];
  logic [TSW-1:0]  trail_a [NPIX];
  logic [IW-1:0]   sel;
  logic            ro_en_q, ro_en_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff1 <= 1'b0;
      rst_s   <= 1'b0;
    end else begin
      rst_ff1 <= 1'b1;
      rst_s   <= rst_ff1;
    end
  end

  for (genvar g = 0; g < NPIX; g++) begin : g_px
    pcr_pixel #(.TSW(TSW)) u_px (
      .clk      (clk),
      .rst_n    (rst_s),
      .disc_i   (disc_i[g]),
      .tstamp_i (tstamp_i),
      .frozen_i (fastor_o),
      .clr_i    (grant[g]),
      .flag_o   (flags[g]),
      .done_o   (dones[g]),
      .lead_o   (lead_a[g]),
      .trail_o  (trail_a[g])
    );
  end

  assign fastor_o = |flags;

  always_comb begin
    ro_en_d = ro_en_q;
    if (!fastor_o)      ro_en_d = 1'b0;
    else if (eoc_ack_i) ro_en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ro_en_q <= 1'b0;
    else        ro_en_q <= ro_en_d;
  end

  pcr_token #(.NPIX(NPIX), .IW(IW)) u_tok (
    .clk     (clk),
    .rst_n   (rst_s),
    .elig_i  (dones),
    .ro_en_i (ro_en_q),
    .ready_i (rec_ready_i),
    .valid_o (rec_valid_o),
    .sel_o   (sel),
    .grant_o (grant)
  );

  assign rec_data_o = {lead_a[sel], trail_a[sel], AW'(sel)};

  // R6
  ro_start_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(ro_en_q) |-> $past(eoc_ack_i));
  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !fastor_o |-> !rec_valid_o);
  // R10
  stall_data_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rec_valid_o && !rec_ready_i) |=> $stable(rec_data_o));
endmodule

// File: tb/tb_pcr_column.sv
module tb_pcr_column;
  localparam int NPIX = 60;
  localparam int TSW  = 8;
  localparam int AW   = 8;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [NPIX-1:0]     disc;
  logic [TSW-1:0]      tstamp;
  logic                ack, rdy;
  logic                fastor, rvalid;
  logic [2*TSW+AW-1:0] rdata;

  pcr_column #(.NPIX(NPIX), .TSW(TSW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .disc_i(disc), .tstamp_i(tstamp),
    .eoc_ack_i(ack), .rec_ready_i(rdy), .fastor_o(fastor),
    .rec_valid_o(rvalid), .rec_data_o(rdata)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int lead_t [NPIX];
  int trail_t[NPIX];
  bit acc[NPIX], got[NPIX];
  int rec_seq[NPIX];
  int nrec, last_addr, loop_valid, base;
  bit order_ok, prev_stall, in_loop;
  logic [2*TSW+AW-1:0] prev_data;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // observe at a falling edge; r is the ready driven for the next rising edge
  task automatic observe(input bit r);
    int a;
    if (prev_stall) begin
      chk(rvalid == 1'b1, "R10 valid held under stall", int'(rvalid), 1);
      chk(rdata == prev_data, "R10 data held under stall", int'(rdata), int'(prev_data));
    end
    if (rvalid && in_loop) loop_valid++;
    prev_stall = rvalid && !r;
    prev_data  = rdata;
    if (rvalid && r) begin
      a = int'(rdata[7:0]);
      if (a >= NPIX || !acc[a]) begin
        chk(0, "R5 record from ignored pixel (R3 addr)", a, -1);
      end else if (got[a]) begin
        chk(0, "R9 duplicate record", a, -1);
      end else begin
        chk(int'(rdata[23:16]) == ((base + lead_t[a]) % 256), "R1 leading stamp",
            int'(rdata[23:16]), (base + lead_t[a]) % 256);
        chk(int'(rdata[15:8]) == ((base + trail_t[a]) % 256), "R2 trailing stamp",
            int'(rdata[15:8]), (base + trail_t[a]) % 256);
        got[a] = 1;
        if (nrec < NPIX) rec_seq[nrec] = a;
        if (a < last_addr) order_ok = 0;
        last_addr = a;
        nrec++;
      end
    end
  endtask

  task automatic clear_hits();
    for (int p = 0; p < NPIX; p++) begin
      lead_t[p] = 0;
      trail_t[p] = 0;
    end
  endtask

  task automatic run_case(input int ack_t, input int tlen, input int pct, input bit ord);
    int minlead, maxtr, nacc;
    bit r;
    minlead = 1000; maxtr = 0; nacc = 0;
    for (int p = 0; p < NPIX; p++)
      if (lead_t[p] > 0 && lead_t[p] < minlead) minlead = lead_t[p];
    for (int p = 0; p < NPIX; p++) begin
      acc[p] = (lead_t[p] > 0) && (lead_t[p] == minlead);
      got[p] = 0;
      if (acc[p]) begin
        nacc++;
        if (trail_t[p] > maxtr) maxtr = trail_t[p];
      end
    end
    nrec = 0; last_addr = -1; order_ok = 1; loop_valid = 0;
    prev_stall = 0; in_loop = 1;
    base = $urandom_range(0, 255);
    for (int t = 1; t <= tlen; t++) begin
      @(negedge clk);
      if (t == minlead) chk(fastor == 1'b0, "R4 fast-OR low before first hit", int'(fastor), 0);
      if (t == minlead + 1) chk(fastor == 1'b1, "R4 fast-OR high after first hit", int'(fastor), 1);
      r = ($urandom_range(1, 100) <= pct);
      observe(r);
      tstamp = TSW'(base + t);
      for (int p = 0; p < NPIX; p++) disc[p] = (lead_t[p] > 0) && (t >= lead_t[p]) && (t < trail_t[p]);
      ack = (t == ack_t);
      rdy = r;
    end
    in_loop = 0;
    if (ack_t <= minlead)
      chk(loop_valid == 0, "R6 early acknowledge ignored", loop_valid, 0);
    for (int d = 0; d < 4 * NPIX + 10; d++) begin
      @(negedge clk);
      r = ($urandom_range(1, 100) <= pct);
      observe(r);
      tstamp = TSW'(base + tlen + d + 1);
      disc = '0;
      ack = (d == 0);
      rdy = r;
    end
    @(negedge clk);
    ack = 0; rdy = 0;
    chk(nrec == nacc, "R9 one record per accepted hit", nrec, nacc);
    chk(fastor == 1'b0, "R11 fast-OR released", int'(fastor), 0);
    chk(rvalid == 1'b0, "R11 valid low after drain", int'(rvalid), 0);
    if (ord && ack_t > maxtr)
      chk(order_ok, "R7 ascending index order", int'(order_ok), 1);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1c0de5));
    rst_n = 0; disc = '0; tstamp = '0; ack = 0; rdy = 0;
    repeat (3) @(negedge clk);
    chk(fastor == 1'b0, "R4 reset fast-OR", int'(fastor), 0);
    chk(rvalid == 1'b0, "R6 reset valid", int'(rvalid), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // single hit on pixel 0 (R1 R2 R3)
    clear_hits();
    lead_t[0] = 2; trail_t[0] = 6;
    run_case(10, 15, 100, 1);
    chk(rec_seq[0] == 0, "R3 address of pixel 0", rec_seq[0], 0);

    // highest and lowest pixel at once, acknowledge after both finish (R7)
    clear_hits();
    lead_t[NPIX-1] = 3; trail_t[NPIX-1] = 5;
    lead_t[0] = 3; trail_t[0] = 8;
    run_case(12, 15, 100, 1);
    chk(rec_seq[0] == 0 && rec_seq[1] == NPIX - 1, "R7 pixel 0 before last pixel",
        rec_seq[1], NPIX - 1);

    // later hit during freeze is dropped (R5)
    clear_hits();
    lead_t[10] = 2; trail_t[10] = 5;
    lead_t[20] = 4; trail_t[20] = 9;
    run_case(15, 20, 70, 1);

    // acknowledge before any hit has no effect (R6)
    clear_hits();
    lead_t[5] = 4; trail_t[5] = 7;
    run_case(2, 14, 100, 1);

    // skip pixel 0 until its trailing edge (R8)
    clear_hits();
    lead_t[0] = 2; trail_t[0] = 40;
    lead_t[7] = 2; trail_t[7] = 4;
    lead_t[3] = 2; trail_t[3] = 5;
    run_case(6, 45, 100, 0);
    chk(rec_seq[0] == 3, "R8 first record", rec_seq[0], 3);
    chk(rec_seq[1] == 7, "R8 second record", rec_seq[1], 7);
    chk(rec_seq[2] == 0, "R8 unfinished pixel presented last", rec_seq[2], 0);

    // stall heavy directed case (R10)
    clear_hits();
    lead_t[1] = 2; trail_t[1] = 3;
    lead_t[2] = 2; trail_t[2] = 3;
    lead_t[30] = 2; trail_t[30] = 4;
    run_case(8, 12, 25, 1);

    // random cases
    for (int c = 0; c < 30; c++) begin
      int ml, k, p;
      clear_hits();
      ml = $urandom_range(2, 6);
      k = $urandom_range(1, 6);
      for (int j = 0; j < k; j++) begin
        p = $urandom_range(0, NPIX - 1);
        if (lead_t[p] == 0) begin
          lead_t[p] = (j > 0 && $urandom_range(0, 2) == 0) ? ml + $urandom_range(1, 10) : ml;
          trail_t[p] = lead_t[p] + $urandom_range(1, 15);
        end
      end
      run_case($urandom_range(1, 38), 40, $urandom_range(30, 100), 1);
    end

    finish_run();
  end
endmodule